// File: doc/BRIEF.md
# PCI Target Narrow-Port Serializer

This block sits between the 64-bit internal view of a PCI target transaction and a narrow user-logic port. When a transaction is accepted, the block first sends its 64-bit address on the outbound narrow port. It then either slices 64-bit write words (with byte enables) onto that port, or collects narrow read pieces from the user logic and packs them into 64-bit read words for the bus side. A mode input picks the port width: two 32-bit pieces per 64-bit value, or four 16-bit pieces. A 4-bit step counter selects the piece on the port in each step.

Bursts that start on an odd 32-bit word (address bit 2 set) are aligned. On a write burst, a leading dummy piece with all byte enables cleared is inserted. On a read burst, the user's first pieces fill the lower 32 bits of the first bus word, and those pieces are discarded. Non-burst transactions carry exactly one data word and get no alignment.

Top module: `tps_serializer`

## Requirements
- R1: After synchronous reset, `txn_ready` is 1 and `up_valid`, `rq_valid`, `dn_ready` and `wq_ready` are 0.
- R2: After a transaction is accepted, the address goes out on `up_data` before any data, with `up_addr`=1, lowest piece first. In 32-bit mode there are two pieces (address bits 31:0, then 63:32) with `up_be`=4'hF. In 16-bit mode there are four 16-bit pieces in bits 15:0 of `up_data`, with bits 31:16 zero and `up_be`=4'h3.
- R3: In 32-bit mode (`mode_16`=0), each write word goes out as bits 31:0 and then bits 63:32. `up_be` carries the matching four byte enables, `wq_be[3:0]` and then `wq_be[7:4]`.
- R4: In 16-bit mode (`mode_16`=1), each write word goes out as four 16-bit quarters, lowest first, in `up_data[15:0]`. `up_be[1:0]` carries the two matching byte enables and `up_be[3:2]` is 0.
- R5: On a 32-bit read, the first accepted `dn_data` piece becomes `rq_data[31:0]` and the second becomes `rq_data[63:32]`.
- R6: On a 16-bit read, four accepted `dn_data[15:0]` quarters become `rq_data` bits 15:0, 31:16, 47:32 and 63:48, in that order.
- R7: On a write burst (`txn_burst`=1) with `txn_addr[2]`=1, the pieces covering bits 31:0 of the first word have `up_data`=0 and `up_be`=0. That is one piece in 32-bit mode and two in 16-bit mode.
- R8: On a read burst with `txn_addr[2]`=1, the user pieces covering bits 31:0 of the first word are accepted but dropped, and those bits of the first `rq_data` word are 0.
- R9: A non-burst transaction carries exactly one 64-bit data word, whatever `txn_len_m1` is, and gets no dummy or dropped piece even when `txn_addr[2]`=1.
- R10: `mode_16` is sampled only when a transaction is accepted. Changing it during a transaction has no effect on that transaction.
- R11: The step counter moves only on a completed handshake. While `up_valid`=1 and `up_ready`=0, `up_valid` stays 1 and `up_data` holds.
- R12: `up_last` is 1 exactly on the final data piece of a write transaction, and 0 on address pieces and during reads.
- R13: A burst carries `txn_len_m1`+1 data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_16 | input | 1 | 1: 16-bit pieces, 0: 32-bit pieces; sampled at acceptance |
| txn_valid | input | 1 | Transaction request |
| txn_ready | output | 1 | Block idle, request accepted |
| txn_addr | input | 64 | Transaction start address |
| txn_write | input | 1 | 1: write, 0: read |
| txn_burst | input | 1 | Burst marker |
| txn_len_m1 | input | LEN_W | Burst length in 64-bit words minus one |
| wq_valid | input | 1 | Bus-side write word valid |
| wq_ready | output | 1 | Write word accepted |
| wq_data | input | 64 | Write word |
| wq_be | input | 8 | Write byte enables, one per byte |
| rq_valid | output | 1 | Packed read word valid |
| rq_ready | input | 1 | Bus side takes the read word |
| rq_data | output | 64 | Packed read word |
| up_valid | output | 1 | Outbound narrow piece valid |
| up_ready | input | 1 | User logic takes the piece |
| up_data | output | 32 | Outbound piece (16-bit mode uses bits 15:0) |
| up_be | output | 4 | Byte enables of the piece |
| up_addr | output | 1 | Piece is part of the address |
| up_last | output | 1 | Final write data piece |
| dn_valid | input | 1 | Inbound read piece valid |
| dn_ready | output | 1 | Inbound piece accepted |
| dn_data | input | 32 | Inbound read piece (16-bit mode uses bits 15:0) |

## Verification
The hold properties assume that the user logic and the bus side follow valid/ready rules. They also assume that write words are offered only while a write transaction is in its data phase. The stimulus drives every input just after a rising edge and changes a payload only after its handshake has been seen. It feeds write words only for write transactions and read pieces only for reads. It supplies exactly the number of words or pieces that the requested length and mode call for, so no piece is offered outside a transaction.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int WORD_W = 64;
  localparam int PORT_W = 32;
  localparam int QTR_W  = 16;
  localparam int BE_W   = WORD_W / 8;
  localparam int PBE_W  = PORT_W / 8;
  localparam int QBE_W  = QTR_W / 8;
  localparam int CNT_W  = 4;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;

  // First counter value of the data steps: after 2 or 4 address pieces.
  function automatic logic [CNT_W-1:0] cnt_base(input logic m16);
    return m16 ? CNT_W'(4) : CNT_W'(2);
  endfunction

  function automatic logic [1:0] last_idx(input logic m16);
    return m16 ? 2'd3 : 2'd1;
  endfunction

  function automatic logic [1:0] data_idx(input logic [CNT_W-1:0] cnt, input logic m16);
    logic [CNT_W-1:0] d;
    d = cnt - cnt_base(m16);
    return d[1:0];
  endfunction

  function automatic logic [PORT_W-1:0] pick_piece(input logic [WORD_W-1:0] w,
                                                   input logic m16, input logic [1:0] i);
    if (m16) return {{(PORT_W-QTR_W){1'b0}}, w[int'(i)*QTR_W +: QTR_W]};
    return w[int'(i[0])*PORT_W +: PORT_W];
  endfunction

  function automatic logic [PBE_W-1:0] pick_be(input logic [BE_W-1:0] be,
                                               input logic m16, input logic [1:0] i);
    if (m16) return {{(PBE_W-QBE_W){1'b0}}, be[int'(i)*QBE_W +: QBE_W]};
    return be[int'(i[0])*PBE_W +: PBE_W];
  endfunction

  function automatic logic [PBE_W-1:0] port_be_mask(input logic m16);
    return m16 ? {{(PBE_W-QBE_W){1'b0}}, {QBE_W{1'b1}}} : {PBE_W{1'b1}};
  endfunction

  function automatic logic [WORD_W-1:0] put_piece(input logic [WORD_W-1:0] w, input logic m16,
                                                  input logic [1:0] i, input logic [PORT_W-1:0] p);
    logic [WORD_W-1:0] r;
    r = w;
    if (m16) r[int'(i)*QTR_W +: QTR_W] = p[QTR_W-1:0];
    else     r[int'(i[0])*PORT_W +: PORT_W] = p;
    return r;
  endfunction

  // Pieces that cover bits 31:0 of a word.
  function automatic logic low_half(input logic m16, input logic [1:0] i);
    return m16 ? !i[1] : (i == 2'd0);
  endfunction
endpackage

// File: rtl/tps_ctrl.sv
module tps_ctrl
  import tps_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  mode_16,
  input  logic                  txn_valid,
  input  logic [WORD_W-1:0]     txn_addr,
  input  logic                  txn_write,
  input  logic                  txn_burst,
  input  logic [LEN_W-1:0]      txn_len_m1,
  input  logic                  step,
  output phase_t                phase,
  output logic [CNT_W-1:0]      cnt,
  output logic                  mode_q,
  output logic                  write_q,
  output logic [WORD_W-1:0]     addr_q,
  output logic [1:0]            idx,
  output logic                  word_end,
  output logic                  final_piece,
  output logic                  dummy
);
  logic             odd_q;
  logic             first_q;
  logic [LEN_W-1:0] left_q;

  always_comb begin
    idx         = (phase == PH_ADDR) ? cnt[1:0] : data_idx(cnt, mode_q);
    word_end    = (idx == last_idx(mode_q));
    final_piece = (phase == PH_DATA) && word_end && (left_q == '0);
    dummy       = (phase == PH_DATA) && odd_q && first_q && low_half(mode_q, idx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      cnt     <= '0;
      mode_q  <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      odd_q   <= 1'b0;
      first_q <= 1'b0;
      left_q  <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: if (txn_valid) begin
          phase   <= PH_ADDR;
          cnt     <= '0;
          mode_q  <= mode_16;
          write_q <= txn_write;
          addr_q  <= txn_addr;
          odd_q   <= txn_burst && txn_addr[2];
          first_q <= 1'b1;
          left_q  <= txn_burst ? txn_len_m1 : '0;
        end
        PH_ADDR: if (step) begin
          if (word_end) begin
            cnt   <= cnt_base(mode_q);
            phase <= PH_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: if (step) begin
          if (word_end) begin
            first_q <= 1'b0;
            if (left_q == '0) begin
              phase <= PH_IDLE;
              cnt   <= '0;
            end else begin
              left_q <= left_q - 1'b1;
              cnt    <= cnt_base(mode_q);
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase != PH_IDLE |-> cnt < (cnt_base(mode_q) << 1));                      // R11
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    phase == PH_IDLE |-> cnt == '0);                                           // R11
  AST_CNT_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && !step) |=> $stable(cnt));                             // R11
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> $stable(mode_q));        // R10
endmodule

// File: rtl/tps_wr_slicer.sv
module tps_wr_slicer
  import tps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] wq_data,
  input  logic [BE_W-1:0]   wq_be,
  input  logic              consume,
  input  logic              mode_q,
  input  logic [1:0]        idx,
  input  logic              dummy,
  output logic              buf_valid,
  output logic [PORT_W-1:0] piece_data,
  output logic [PBE_W-1:0]  piece_be
);
  logic [WORD_W-1:0] word_q;
  logic [BE_W-1:0]   be_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_valid <= 1'b0;
      word_q    <= '0;
      be_q      <= '0;
    end else if (load) begin
      buf_valid <= 1'b1;
      word_q    <= wq_data;
      be_q      <= wq_be;
    end else if (consume) begin
      buf_valid <= 1'b0;
    end
  end

  always_comb begin
    piece_data = dummy ? '0 : pick_piece(word_q, mode_q, idx);
    piece_be   = dummy ? '0 : pick_be(be_q, mode_q, idx);
  end

  AST_NO_LOAD_OVER_WORD: assert property (@(posedge clk) disable iff (rst)
    load |-> !buf_valid);                                                      // R3
  AST_CONSUME_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
    consume |-> buf_valid);                                                    // R4
endmodule

// File: rtl/tps_rd_packer.sv
module tps_rd_packer
  import tps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [PORT_W-1:0] dn_data,
  input  logic              mode_q,
  input  logic [1:0]        idx,
  input  logic              word_end,
  input  logic              dummy,
  input  logic              rq_ready,
  output logic              rq_valid,
  output logic [WORD_W-1:0] rq_data
);
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_next;

  always_comb acc_next = put_piece(acc_q, mode_q, idx, dummy ? '0 : dn_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= '0;
      rq_valid <= 1'b0;
      rq_data  <= '0;
    end else begin
      if (rq_valid && rq_ready) rq_valid <= 1'b0;
      if (take) begin
        if (word_end) begin
          rq_data  <= acc_next;
          rq_valid <= 1'b1;
          acc_q    <= '0;
        end else begin
          acc_q <= acc_next;
        end
      end
    end
  end

  AST_RQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rq_valid && !rq_ready) |=> (rq_valid && $stable(rq_data)));               // R5
  AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    take |-> !rq_valid);                                                       // R6
endmodule

// File: rtl/tps_serializer.sv
module tps_serializer
  import tps_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_16,
  input  logic              txn_valid,
  output logic              txn_ready,
  input  logic [WORD_W-1:0] txn_addr,
  input  logic              txn_write,
  input  logic              txn_burst,
  input  logic [LEN_W-1:0]  txn_len_m1,
  input  logic              wq_valid,
  output logic              wq_ready,
  input  logic [WORD_W-1:0] wq_data,
  input  logic [BE_W-1:0]   wq_be,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [WORD_W-1:0] rq_data,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [PORT_W-1:0] up_data,
  output logic [PBE_W-1:0]  up_be,
  output logic              up_addr,
  output logic              up_last,
  input  logic              dn_valid,
  output logic              dn_ready,
  input  logic [PORT_W-1:0] dn_data
);
  phase_t             phase;
  logic [CNT_W-1:0]   cnt;
  logic               mode_q, write_q;
  logic [WORD_W-1:0]  addr_q;
  logic [1:0]         idx;
  logic               word_end, final_piece, dummy;
  logic               buf_valid;
  logic [PORT_W-1:0]  wr_piece;
  logic [PBE_W-1:0]   wr_be;
  logic               up_fire, dn_fire, step, wq_fire, wr_consume;

  always_comb begin
    txn_ready  = (phase == PH_IDLE);
    up_addr    = (phase == PH_ADDR);
    up_valid   = up_addr || ((phase == PH_DATA) && write_q && buf_valid);
    up_data    = up_addr ? pick_piece(addr_q, mode_q, idx) : wr_piece;
    up_be      = up_addr ? port_be_mask(mode_q) : wr_be;
    up_last    = write_q && final_piece && buf_valid;
    wq_ready   = (phase == PH_DATA) && write_q && !buf_valid;
    dn_ready   = (phase == PH_DATA) && !write_q && !rq_valid;
    up_fire    = up_valid && up_ready;
    dn_fire    = dn_valid && dn_ready;
    wq_fire    = wq_valid && wq_ready;
    step       = (up_addr || write_q) ? up_fire : dn_fire;
    wr_consume = up_fire && (phase == PH_DATA) && word_end;
  end

  tps_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .mode_16(mode_16), .txn_valid(txn_valid),
    .txn_addr(txn_addr), .txn_write(txn_write), .txn_burst(txn_burst),
    .txn_len_m1(txn_len_m1), .step(step), .phase(phase), .cnt(cnt),
    .mode_q(mode_q), .write_q(write_q), .addr_q(addr_q), .idx(idx),
    .word_end(word_end), .final_piece(final_piece), .dummy(dummy)
  );

  tps_wr_slicer u_slicer (
    .clk(clk), .rst(rst), .load(wq_fire), .wq_data(wq_data), .wq_be(wq_be),
    .consume(wr_consume), .mode_q(mode_q), .idx(idx), .dummy(dummy),
    .buf_valid(buf_valid), .piece_data(wr_piece), .piece_be(wr_be)
  );

  tps_rd_packer u_packer (
    .clk(clk), .rst(rst), .take(dn_fire), .dn_data(dn_data), .mode_q(mode_q),
    .idx(idx), .word_end(word_end), .dummy(dummy), .rq_ready(rq_ready),
    .rq_valid(rq_valid), .rq_data(rq_data)
  );

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_ready) |=> (up_valid && $stable(up_data) && $stable(up_be))); // R11
  AST_DUMMY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (up_valid && dummy) |-> (up_be == '0 && up_data == '0));                  // R7
  AST_LAST_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    up_last |-> (up_valid && !up_addr));                                       // R12
  AST_ADDR_NOT_LAST: assert property (@(posedge clk) disable iff (rst)
    up_addr |-> !up_last);                                                     // R2
endmodule

// File: tb/tb_tps_serializer.sv
module tb_tps_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_16 = 1'b0;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic [63:0] txn_addr = '0;
  logic        txn_write = 1'b0;
  logic        txn_burst = 1'b0;
  logic [3:0]  txn_len_m1 = '0;
  logic        wq_valid = 1'b0;
  logic        wq_ready;
  logic [63:0] wq_data = '0;
  logic [7:0]  wq_be = '0;
  logic        rq_valid;
  logic        rq_ready = 1'b0;
  logic [63:0] rq_data;
  logic        up_valid;
  logic        up_ready = 1'b0;
  logic [31:0] up_data;
  logic [3:0]  up_be;
  logic        up_addr;
  logic        up_last;
  logic        dn_valid = 1'b0;
  logic        dn_ready;
  logic [31:0] dn_data = '0;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit up_en = 1'b1;

  logic [31:0] q_d[$];
  logic [3:0]  q_b[$];
  bit          q_a[$];
  bit          q_l[$];
  string       q_t[$];
  logic [63:0] r_d[$];
  string       r_t[$];

  tps_serializer #(.LEN_W(4)) dut (
    .clk(clk), .rst(rst), .mode_16(mode_16), .txn_valid(txn_valid), .txn_ready(txn_ready),
    .txn_addr(txn_addr), .txn_write(txn_write), .txn_burst(txn_burst), .txn_len_m1(txn_len_m1),
    .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_data(wq_data), .wq_be(wq_be),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_data(rq_data),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data), .up_be(up_be),
    .up_addr(up_addr), .up_last(up_last),
    .dn_valid(dn_valid), .dn_ready(dn_ready), .dn_data(dn_data)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Sink readiness patterns, updated just after each rising edge.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    up_ready = up_en && ((cyc % 3) != 2);
    rq_ready = ((cyc % 4) != 1);
  end

  // Watchdog.
  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    finish_run();
  end

  // Monitor: handshakes seen mid-cycle complete at the next rising edge.
  always @(negedge clk) begin
    if (!rst && up_valid && up_ready) begin
      if (q_d.size() == 0) begin
        chk(1'b0, "R2", "unexpected up piece", 64'(up_data), 64'h0);
      end else begin
        logic [31:0] ed;
        logic [3:0]  eb;
        bit          ea, el;
        string       et;
        ed = q_d.pop_front(); eb = q_b.pop_front(); ea = q_a.pop_front();
        el = q_l.pop_front(); et = q_t.pop_front();
        chk(up_data == ed, et, "up_data", 64'(up_data), 64'(ed));
        chk(up_be == eb, et, "up_be", 64'(up_be), 64'(eb));
        chk(up_addr == ea, et, "up_addr", 64'(up_addr), 64'(ea));
        chk(up_last == el, "R12", "up_last", 64'(up_last), 64'(el));
      end
    end
    if (!rst && rq_valid && rq_ready) begin
      if (r_d.size() == 0) begin
        chk(1'b0, "R5", "unexpected read word", rq_data, 64'h0);
      end else begin
        logic [63:0] ew;
        string       et;
        ew = r_d.pop_front(); et = r_t.pop_front();
        chk(rq_data == ew, et, "rq_data", rq_data, ew);
      end
    end
  end

  function automatic logic [63:0] mkw(input int s, input int k);
    return {32'(s * 7919 + k * 131 + 17), 32'((s * 104729) ^ (k << 9) ^ 32'h5a5a0f0f)};
  endfunction

  function automatic logic [7:0] mkbe(input int s, input int k);
    return 8'(s * 29 + k * 53 + 3);
  endfunction

  task automatic push_up(input logic [31:0] d, input logic [3:0] b, input bit a,
                         input bit l, input string t);
    q_d.push_back(d); q_b.push_back(b); q_a.push_back(a); q_l.push_back(l); q_t.push_back(t);
  endtask

  task automatic push_addr(input logic [63:0] a, input bit m16);
    int np, qw;
    np = m16 ? 4 : 2;
    qw = m16 ? 16 : 32;
    for (int i = 0; i < np; i++)
      push_up(32'(a >> (i * qw)) & (m16 ? 32'h0000ffff : 32'hffffffff),
              m16 ? 4'h3 : 4'hf, 1'b1, 1'b0, "R2");
  endtask

  task automatic start_txn(input logic [63:0] a, input bit wr, input bit burst,
                           input logic [3:0] lm1);
    @(posedge clk); #1;
    txn_valid = 1'b1; txn_addr = a; txn_write = wr; txn_burst = burst; txn_len_m1 = lm1;
    do @(negedge clk); while (!txn_ready);
    @(posedge clk); #1;
    txn_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t;
    t = 0;
    while ((q_d.size() != 0 || r_d.size() != 0 || !txn_ready || rq_valid) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, tag, "transaction completes", 64'(t), 64'd3000);
  endtask

  task automatic run_write(input logic [63:0] a, input bit m16, input bit burst,
                           input int nw, input int seed, input string tag, input bit flip);
    int np, qw, eff;
    np  = m16 ? 4 : 2;
    qw  = m16 ? 16 : 32;
    eff = burst ? nw : 1;
    push_addr(a, m16);
    for (int k = 0; k < eff; k++) begin
      for (int i = 0; i < np; i++) begin
        logic [31:0] d;
        logic [3:0]  e;
        d = 32'(mkw(seed, k) >> (i * qw)) & (m16 ? 32'h0000ffff : 32'hffffffff);
        e = 4'(mkbe(seed, k) >> (i * qw / 8)) & (m16 ? 4'h3 : 4'hf);
        if (burst && a[2] && k == 0 && (i * qw) < 32) begin
          d = '0;
          e = '0;
        end
        push_up(d, e, 1'b0, (k == eff - 1) && (i == np - 1), tag);
      end
    end
    mode_16 = m16;
    start_txn(a, 1'b1, burst, 4'(nw - 1));
    if (flip) mode_16 = !m16;
    for (int k = 0; k < eff; k++) begin
      wq_valid = 1'b1; wq_data = mkw(seed, k); wq_be = mkbe(seed, k);
      do @(negedge clk); while (!wq_ready);
      @(posedge clk); #1;
      wq_valid = 1'b0;
    end
    wait_done(tag);
  endtask

  task automatic run_read(input logic [63:0] a, input bit m16, input bit burst,
                          input int nw, input int seed, input string tag);
    int np, qw, eff;
    np  = m16 ? 4 : 2;
    qw  = m16 ? 16 : 32;
    eff = burst ? nw : 1;
    push_addr(a, m16);
    for (int k = 0; k < eff; k++) begin
      logic [63:0] w;
      w = mkw(seed, k);
      if (burst && a[2] && k == 0) w[31:0] = '0;
      r_d.push_back(w); r_t.push_back(tag);
    end
    mode_16 = m16;
    start_txn(a, 1'b0, burst, 4'(nw - 1));
    for (int k = 0; k < eff; k++) begin
      for (int i = 0; i < np; i++) begin
        logic [31:0] p;
        p = 32'(mkw(seed, k) >> (i * qw)) & (m16 ? 32'h0000ffff : 32'hffffffff);
        if (burst && a[2] && k == 0 && (i * qw) < 32) p = 32'hbad00000 | 32'(i);
        dn_valid = 1'b1; dn_data = p;
        do @(negedge clk); while (!dn_ready);
        @(posedge clk); #1;
        dn_valid = 1'b0;
      end
    end
    wait_done(tag);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(txn_ready == 1'b1, "R1", "txn_ready", 64'(txn_ready), 64'd1);
    chk(up_valid == 1'b0, "R1", "up_valid", 64'(up_valid), 64'd0);
    chk(rq_valid == 1'b0, "R1", "rq_valid", 64'(rq_valid), 64'd0);
    chk(dn_ready == 1'b0, "R1", "dn_ready", 64'(dn_ready), 64'd0);
    chk(wq_ready == 1'b0, "R1", "wq_ready", 64'(wq_ready), 64'd0);

    run_write(64'h1234_5678_9abc_def0, 1'b0, 1'b1, 3, 1, "R3", 1'b0);
    run_write(64'hfedc_ba98_7654_3210, 1'b1, 1'b1, 2, 2, "R4", 1'b0);
    run_read (64'h0000_0001_0000_0100, 1'b0, 1'b1, 3, 3, "R5");
    run_read (64'h8000_0000_4000_0020, 1'b1, 1'b1, 2, 4, "R6");
    run_write(64'h0000_0000_0000_1004, 1'b0, 1'b1, 2, 5, "R7", 1'b0);
    run_write(64'h0000_00aa_0000_200c, 1'b1, 1'b1, 2, 6, "R7", 1'b0);
    run_read (64'h0000_0000_0000_3004, 1'b0, 1'b1, 2, 7, "R8");
    run_read (64'h0000_0000_5555_400c, 1'b1, 1'b1, 3, 8, "R8");
    run_write(64'h0000_0000_0000_5004, 1'b0, 1'b0, 4, 9, "R9", 1'b0);
    run_read (64'h0000_0000_0000_6004, 1'b1, 1'b0, 4, 10, "R9");
    run_write(64'h1111_2222_3333_4444, 1'b1, 1'b1, 2, 11, "R10", 1'b1);
    run_write(64'h0000_0000_0000_7000, 1'b0, 1'b1, 16, 12, "R13", 1'b0);

    // R11: stall the narrow port during the address phase.
    up_en = 1'b0;
    repeat (2) @(posedge clk);
    begin
      logic [63:0] a;
      logic [31:0] d0;
      a = 64'hcafe_f00d_0bad_beef;
      push_addr(a, 1'b0);
      push_up(mkw(13, 0) & 64'hffffffff, mkbe(13, 0) & 8'h0f, 1'b0, 1'b0, "R11");
      push_up(32'(mkw(13, 0) >> 32), 4'(mkbe(13, 0) >> 4), 1'b0, 1'b1, "R11");
      mode_16 = 1'b0;
      start_txn(a, 1'b1, 1'b0, 4'd0);
      @(negedge clk);
      d0 = up_data;
      for (int n = 0; n < 5; n++) begin
        @(negedge clk);
        chk(up_valid && up_data == d0, "R11", "held piece while stalled", 64'(up_data), 64'(d0));
      end
      chk(d0 == a[31:0], "R11", "held piece value", 64'(d0), 64'(a[31:0]));
      up_en = 1'b1;
      wq_valid = 1'b1; wq_data = mkw(13, 0); wq_be = mkbe(13, 0);
      do @(negedge clk); while (!wq_ready);
      @(posedge clk); #1;
      wq_valid = 1'b0;
      wait_done("R11");
    end

    repeat (4) @(negedge clk);
    chk(q_d.size() == 0 && r_d.size() == 0, "R12", "scoreboard drained",
        64'(q_d.size() + r_d.size()), 64'd0);
    finish_run();
  end
endmodule